// File: doc/BRIEF.md
# Byte-Serial Result Output Port

This block takes a 16-bit conversion result, offered with a one-cycle valid pulse, and hands it to a host over an 8-bit data bus as two bytes in a row. A single strobe line frames the exchange. The strobe rises while the first byte is on the bus and falls while the second byte is on the bus, so one high pulse carries one whole result. Outside a transfer the strobe stays low.

Two select inputs shape each transfer. One picks whether the upper or the lower half of the result goes out first. The other picks the output coding: complemented offset binary or complemented two's complement. Both selects are sampled when a transfer begins.

A result that arrives while a transfer is under way waits in a one-entry holding register. It is sent immediately after the current transfer ends. If another result arrives while that register is full, the newer one replaces the waiting one and a sticky overrun flag is set. Each byte stays on the bus for `HOLD_CYC` cycles before the strobe edge that marks it, and for `HOLD_CYC` cycles after that edge.

Top module: `byte_port_tx`

## Requirements
- R1: After reset, `bus_data` is 0 and `bus_strobe`, `busy` and `overrun` are all low.
- R2: With `twos_fmt`=0, the 16-bit word sent is the bitwise complement of `res_data` (complemented offset binary).
- R3: With `twos_fmt`=1, the word sent is the bitwise complement of `res_data` with bit 15 inverted, i.e. ~(res_data ^ 16'h8000) (complemented two's complement).
- R4: With `hi_first`=1, bits 15:8 of the sent word go out first and bits 7:0 go out second. With `hi_first`=0, the order is reversed.
- R5: Suppose a valid result is sampled while the block is idle. From the next cycle, `busy` is high for exactly 4*HOLD_CYC cycles. The phases run in this order, each HOLD_CYC cycles long: first byte with strobe low, first byte with strobe high, second byte with strobe high, second byte with strobe low.
- R6: `bus_strobe` is low whenever `busy` is low, so each transfer is exactly one high pulse. While idle, the bus keeps the second byte of the last transfer.
- R7: The selects are sampled in the cycle a transfer starts. Changing them during the transfer does not change any byte of that transfer.
- R8: A result that arrives during a transfer is held. Its transfer starts in the cycle right after the current one ends, so `busy` does not drop between the two.
- R9: A result that arrives while the holding register is already full replaces the held result. It also sets `overrun`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_data | input | 16 | Straight-binary conversion result |
| res_valid | input | 1 | One-cycle pulse: `res_data` holds a new result |
| hi_first | input | 1 | 1: upper byte first; 0: lower byte first |
| twos_fmt | input | 1 | 1: complemented two's complement; 0: complemented offset binary |
| bus_data | output | 8 | Byte presented to the host |
| bus_strobe | output | 1 | Rises with the first byte, falls with the second |
| busy | output | 1 | A transfer is in progress |
| overrun | output | 1 | Sticky: a held result was overwritten |

## Verification
The bench sweeps hundreds of result values across all four select combinations. It checks every cycle of each transfer against byte values and strobe phases that it computes arithmetically. That catches a flipped MSB, a swapped byte order, or a strobe edge that lands one cycle off the byte change. On alternate transfers the bench toggles the selects partway through, which exposes a design that reads the selects live instead of latching them. Separate runs land a second result mid-transfer, and a third one on top of it. A design that drops a cycle between chained transfers, sends the older held value, or lets the overrun flag clear would fail these runs.

// File: rtl/byte_port_pkg.sv
package byte_port_pkg;

  typedef enum logic [1:0] {
    PH_LEAD   = 2'd0,
    PH_RISE   = 2'd1,
    PH_SECOND = 2'd2,
    PH_TRAIL  = 2'd3
  } phase_t;

endpackage

// File: rtl/byte_port_fmt.sv
module byte_port_fmt #(
  parameter int RES_W = 16
) (
  input  logic [RES_W-1:0] raw,
  input  logic             twos_fmt,
  input  logic             hi_first,
  output logic [RES_W-1:0] ordered
);
  localparam int HALF = RES_W / 2;

  logic [RES_W-1:0] msb_flip;
  logic [RES_W-1:0] coded;

  always_comb begin
    msb_flip = '0;
    msb_flip[RES_W-1] = twos_fmt;
    coded = ~(raw ^ msb_flip);
    if (hi_first) ordered = coded;
    else          ordered = {coded[HALF-1:0], coded[RES_W-1:HALF]};
  end
endmodule

// File: rtl/byte_port_hold.sv
module byte_port_hold #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_valid,
  input  logic             busy,
  input  logic             done,
  output logic             hold_full,
  output logic [RES_W-1:0] hold_data,
  output logic             overrun
);
  logic             full_d;
  logic             ovr_d;
  logic             put;
  logic             take;

  always_comb begin
    take   = done & hold_full;
    put    = res_valid & busy & ~(done & ~hold_full);
    full_d = put | (hold_full & ~take);
    ovr_d  = overrun | (res_valid & busy & hold_full & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      hold_full <= full_d;
      overrun   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hold_data <= '0;
    else if (put) hold_data <= res_data;
  end

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !done) |=> hold_full);
endmodule

// File: rtl/byte_port_seq.sv
module byte_port_seq
  import byte_port_pkg::*;
#(
  parameter int RES_W    = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RES_W-1:0] start_word,
  output logic             busy,
  output logic             done,
  output logic             strobe,
  output logic [RES_W/2-1:0] byte_out
);
  localparam int HALF  = RES_W / 2;
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_d;
  logic [RES_W-1:0] word_q;
  logic             seg_end;

  always_comb begin
    seg_end = busy && (cnt_q == CNT_LAST);
    done    = seg_end && (phase_q == PH_TRAIL);
    phase_d = phase_q;
    cnt_d   = cnt_q;
    busy_d  = busy;
    if (busy) begin
      if (seg_end) begin
        cnt_d = '0;
        if (phase_q != PH_TRAIL) phase_d = phase_t'(phase_q + 2'd1);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (start) begin
      phase_d = PH_LEAD;
      cnt_d   = '0;
      busy_d  = 1'b1;
    end else if (done) begin
      busy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_TRAIL;
      cnt_q   <= '0;
      busy    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      busy    <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (start) word_q <= start_word;
  end

  always_comb begin
    strobe   = busy && ((phase_q == PH_RISE) || (phase_q == PH_SECOND));
    byte_out = (phase_q == PH_LEAD || phase_q == PH_RISE) ? word_q[RES_W-1:HALF]
                                                          : word_q[HALF-1:0];
  end

  assert_busy_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/byte_port_tx.sv
module byte_port_tx #(
  parameter int RES_W    = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_valid,
  input  logic             hi_first,
  input  logic             twos_fmt,
  output logic [RES_W/2-1:0] bus_data,
  output logic             bus_strobe,
  output logic             busy,
  output logic             overrun
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             done;
  logic             hold_full;
  logic [RES_W-1:0] hold_data;
  logic             start;
  logic [RES_W-1:0] src_word;
  logic [RES_W-1:0] ordered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    start    = (~busy | done) & (hold_full | res_valid);
    src_word = hold_full ? hold_data : res_data;
  end

  byte_port_fmt #(.RES_W(RES_W)) i_fmt (
    .raw      (src_word),
    .twos_fmt (twos_fmt),
    .hi_first (hi_first),
    .ordered  (ordered)
  );

  byte_port_hold #(.RES_W(RES_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .res_data  (res_data),
    .res_valid (res_valid),
    .busy      (busy),
    .done      (done),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .overrun   (overrun)
  );

  byte_port_seq #(.RES_W(RES_W), .HOLD_CYC(HOLD_CYC)) i_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .start_word (ordered),
    .busy       (busy),
    .done       (done),
    .strobe     (bus_strobe),
    .byte_out   (bus_data)
  );

  assert_strobe_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> !bus_strobe);
  assert_rise_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(bus_strobe) |-> $stable(bus_data));
  assert_fall_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(bus_strobe) |-> $stable(bus_data));
endmodule

// File: tb/test_byte_port_tx.sv
`timescale 1ns/1ps
module test_byte_port_tx;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;

  logic        clk;
  logic        rst_n;
  logic [15:0] res_data;
  logic        res_valid;
  logic        hi_first;
  logic        twos_fmt;
  logic [7:0]  bus_data;
  logic        bus_strobe;
  logic        busy;
  logic        overrun;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit ended  = 0;

  byte_port_tx #(.RES_W(16), .HOLD_CYC(N)) i_byte_port_tx (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .hi_first(hi_first), .twos_fmt(twos_fmt), .bus_data(bus_data),
    .bus_strobe(bus_strobe), .busy(busy), .overrun(overrun)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] enc(input logic [15:0] v, input bit tw);
    int u;
    u = tw ? ((int'(v) + 32768) % 65536) : int'(v);
    return 16'(65535 - u);
  endfunction

  function automatic logic [7:0] first_b(input logic [15:0] e, input bit hi);
    return hi ? e[15:8] : e[7:0];
  endfunction

  function automatic logic [7:0] second_b(input logic [15:0] e, input bit hi);
    return hi ? e[7:0] : e[15:8];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  task automatic start_xfer(input logic [15:0] v, input bit hi, input bit tw);
    res_data = v; res_valid = 1; hi_first = hi; twos_fmt = tw;
    @(negedge clk);
    res_valid = 0;
  endtask

  // Entered at sample k=0 of a transfer; leaves at sample k=4N.
  task automatic expect_xfer(input logic [15:0] v, input bit hi, input bit tw,
                             input bit flip, input string req,
                             input int k1, input logic [15:0] v1,
                             input int k2, input logic [15:0] v2);
    logic [15:0] e;
    e = enc(v, tw);
    for (int k = 0; k < 4*N; k++) begin
      if (k == 1 && flip) begin hi_first = ~hi; twos_fmt = ~tw; end
      chk({req, " busy R5"}, 16'(busy), 16'd1);
      chk({req, " strobe R5"}, 16'(bus_strobe), 16'((k >= N && k < 3*N) ? 1 : 0));
      chk({req, " data R4"}, 16'(bus_data), 16'(k < 2*N ? first_b(e, hi) : second_b(e, hi)));
      if (k == k1) begin res_data = v1; res_valid = 1; end
      else if (k == k2) begin res_data = v2; res_valid = 1; end
      @(negedge clk);
      res_valid = 0;
    end
  endtask

  task automatic expect_idle(input logic [15:0] v, input bit hi, input bit tw);
    chk("idle busy R5", 16'(busy), 16'd0);
    chk("idle strobe R6", 16'(bus_strobe), 16'd0);
    chk("idle bus keeps second byte R6", 16'(bus_data), 16'(second_b(enc(v, tw), hi)));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !ended) begin
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 0; res_data = 0; res_valid = 0; hi_first = 1; twos_fmt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 bus", 16'(bus_data), 16'd0);
    chk("R1 strobe", 16'(bus_strobe), 16'd0);
    chk("R1 busy", 16'(busy), 16'd0);
    chk("R1 overrun", 16'(overrun), 16'd0);

    // Corner values, all modes (R2 offset binary, R3 two's complement)
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 6; c++) begin
        case (c)
          0: v = 16'h0000; 1: v = 16'h8000; 2: v = 16'h7FFF;
          3: v = 16'hFFFF; 4: v = 16'h1234; default: v = 16'h00FF;
        endcase
        start_xfer(v, m[0], m[1]);
        expect_xfer(v, m[0], m[1], 0, m[1] ? "R3 corner" : "R2 corner", -1, 0, -1, 0);
        expect_idle(v, m[0], m[1]);
      end
    end

    // Sweep with select changes mid-transfer on odd steps (R7)
    for (int i = 0; i < 256; i++) begin
      for (int m = 0; m < 4; m++) begin
        v = 16'((i * 257) ^ (i << 5) ^ (m * 4099));
        start_xfer(v, m[0], m[1]);
        expect_xfer(v, m[0], m[1], i[0], i[0] ? "R7 sweep" : "R2/R3 sweep", -1, 0, -1, 0);
        hi_first = m[0]; twos_fmt = m[1];
        expect_idle(v, m[0], m[1]);
      end
    end

    // R8: second result during transfer is chained with no gap
    start_xfer(16'hA55A, 1, 0);
    hi_first = 0; twos_fmt = 1;
    expect_xfer(16'hA55A, 1, 0, 0, "R8 first", 3, 16'h0F0F, -1, 0);
    expect_xfer(16'h0F0F, 0, 1, 0, "R8 chained", -1, 0, -1, 0);
    expect_idle(16'h0F0F, 0, 1);
    chk("R9 no overrun after single hold", 16'(overrun), 16'd0);

    // R9: third result overwrites held one and sets sticky overrun
    start_xfer(16'h1357, 1, 1);
    expect_xfer(16'h1357, 1, 1, 0, "R9 first", 1, 16'h2222, 3, 16'hBEEF);
    chk("R9 overrun set", 16'(overrun), 16'd1);
    expect_xfer(16'hBEEF, 1, 1, 0, "R9 newest sent", -1, 0, -1, 0);
    expect_idle(16'hBEEF, 1, 1);
    repeat (5) @(negedge clk);
    chk("R9 overrun sticky", 16'(overrun), 16'd1);

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule